// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit performs 32-bit integer multiplication and division over several clock cycles. It keeps the results in a dedicated pair of registers, HI and LO. A command carries a 6-bit function code and two operands, and is taken through a valid/ready handshake. A multiply leaves the 64-bit product split across the pair. A divide leaves the quotient in LO and the remainder in HI. No result goes to a general destination register.

The same command port carries the two move-from reads, which return HI or LO on a response port. The unit takes one operand bit per clock cycle, using shift-add for products and restoring shift-subtract for quotients. While an operation runs, `busy` is high and `cmd_ready` is low. Any further command or read waits at the port until the running operation completes.

Top module: `muldiv_hilo`

## Requirements
- R1: After a synchronous reset, HI and LO are zero, `busy` and `rsp_valid` are low, and `cmd_ready` is high.
- R2: Function code 0x18 multiplies the operands as two's-complement numbers. The low 32 bits of the 64-bit product go to LO and the high 32 bits go to HI.
- R3: Function code 0x19 multiplies the operands as unsigned numbers and splits the 64-bit product the same way (low half to LO, high half to HI).
- R4: Function code 0x1A divides rs by rt as signed numbers. The quotient rounds toward zero and goes to LO. The remainder carries the sign of the dividend and goes to HI. The case 0x80000000 divided by -1 yields LO=0x80000000 and HI=0.
- R5: Function code 0x1B divides rs by rt as unsigned numbers, with the quotient in LO and the remainder in HI.
- R6: A divide by zero, signed or unsigned, raises no error. It sets LO to all ones and HI to the unmodified dividend.
- R7: After a multiply or divide is accepted, `busy` stays high for exactly WIDTH+1 cycles and `cmd_ready` stays low during that time. HI and LO change only in the cycle in which `busy` falls.
- R8: Function code 0x10 reads HI and function code 0x12 reads LO. In the cycle after acceptance, `rsp_valid` is high for one cycle and `rsp_data` holds the register's value.
- R9: A command or read presented while `busy` is high is not accepted until the running operation completes. A read held in this way returns the new result.
- R10: Any other function code is accepted but has no effect. It produces no response, does not raise `busy`, and leaves HI and LO unchanged.
- R11: The low bit of the function code selects the unsigned form of an operation, and bit 1 selects divide over multiply. Codes 0x18 through 0x1B start an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_funct | input | 6 | Function code of the command |
| cmd_rs | input | WIDTH | First operand (multiplicand or dividend) |
| cmd_rt | input | WIDTH | Second operand (multiplier or divisor) |
| busy | output | 1 | An operation is in progress |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | WIDTH | HI or LO value returned by a read |

## Verification
The bench targets the sign corners: the most negative value times itself, minus one squared, mixed-sign division, and the one signed quotient that overflows. A unit that applied the sign correction to the wrong register, or that rounded toward minus infinity, would return off-by-one quotients or remainders with the wrong sign. Divide by zero is checked in both forms, because an unguarded divider would return a sign-flipped quotient or a magnitude in place of the raw dividend. Reads and commands issued during an operation, and unknown function codes, are also checked: a unit without the stall would return stale HI/LO values, and one that did not ignore unknown codes would corrupt the pair.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
  localparam logic [5:0] FN_MFHI  = 6'h10;
  localparam logic [5:0] FN_MFLO  = 6'h12;
  localparam logic [5:0] FN_MULT  = 6'h18;
  localparam logic [5:0] FN_MULTU = 6'h19;
  localparam logic [5:0] FN_DIV   = 6'h1A;
  localparam logic [5:0] FN_DIVU  = 6'h1B;

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DIV} md_state_t;

  // Codes 0x18..0x1B share the upper four bits 0110
  function automatic logic fn_is_arith(input logic [5:0] f);
    return f[5:2] == 4'b0110;
  endfunction

  function automatic logic fn_is_read(input logic [5:0] f);
    return (f == FN_MFHI) || (f == FN_MFLO);
  endfunction
endpackage

// File: rtl/md_operand_prep.sv
`timescale 1ns/1ps
module md_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             signed_mode,
  output logic [WIDTH-1:0] mag_a,
  output logic [WIDTH-1:0] mag_b,
  output logic             neg_a,
  output logic             neg_b
);
  always_comb begin
    neg_a = signed_mode & op_a[WIDTH-1];
    neg_b = signed_mode & op_b[WIDTH-1];
    mag_a = neg_a ? (~op_a + 1'b1) : op_a;
    mag_b = neg_b ? (~op_b + 1'b1) : op_b;
  end
endmodule

// File: rtl/md_mul_core.sv
`timescale 1ns/1ps
module md_mul_core #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [2*WIDTH-1:0] acc_q;
  logic [WIDTH-1:0]   mc_q;
  logic [CW-1:0]      cnt_q;
  logic               run_q;
  logic [WIDTH:0]     sum;

  always_comb begin
    sum = {1'b0, acc_q[2*WIDTH-1:WIDTH]} + (acc_q[0] ? {1'b0, mc_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      mc_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc_q <= {{WIDTH{1'b0}}, mplier};
        mc_q  <= mcand;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        acc_q <= {sum, acc_q[WIDTH-1:1]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(WIDTH - 1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign product = acc_q;
endmodule

// File: rtl/md_div_core.sv
`timescale 1ns/1ps
module md_div_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             done,
  output logic [WIDTH-1:0] quot,
  output logic [WIDTH-1:0] rem
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;
  logic [WIDTH:0]   shifted, trial;
  logic             take;

  always_comb begin
    shifted = {rem_q, quo_q[WIDTH-1]};
    trial   = shifted - {1'b0, dvs_q};
    take    = ~trial[WIDTH];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= take ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
        quo_q <= {quo_q[WIDTH-2:0], take};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(WIDTH - 1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quot = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/muldiv_hilo.sv
`timescale 1ns/1ps
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [5:0]       cmd_funct,
  input  logic [WIDTH-1:0] cmd_rs,
  input  logic [WIDTH-1:0] cmd_rt,
  output logic             busy,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_data
);
  md_state_t        state_q;
  logic [WIDTH-1:0] hi_q, lo_q;
  logic             neg_res_q, neg_rem_q, dz_q;
  logic [WIDTH-1:0] dvd_q;

  logic accept, arith, signed_mode, mul_start, div_start;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic neg_a, neg_b;
  logic mul_done, div_done;
  logic [2*WIDTH-1:0] product, prod_fix;
  logic [WIDTH-1:0] quot, rem;

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);

  always_comb begin
    accept      = cmd_valid && cmd_ready;
    arith       = accept && fn_is_arith(cmd_funct);
    signed_mode = ~cmd_funct[0];
    mul_start   = arith && ~cmd_funct[1];
    div_start   = arith &&  cmd_funct[1];
  end

  md_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .op_a(cmd_rs), .op_b(cmd_rt), .signed_mode(signed_mode),
    .mag_a(mag_a), .mag_b(mag_b), .neg_a(neg_a), .neg_b(neg_b)
  );

  md_mul_core #(.WIDTH(WIDTH)) u_mul (
    .clk(clk), .rst(rst), .start(mul_start), .mcand(mag_a), .mplier(mag_b),
    .done(mul_done), .product(product)
  );

  md_div_core #(.WIDTH(WIDTH)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .dividend(mag_a), .divisor(mag_b),
    .done(div_done), .quot(quot), .rem(rem)
  );

  assign prod_fix = neg_res_q ? (~product + 1'b1) : product;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      hi_q      <= '0;
      lo_q      <= '0;
      neg_res_q <= 1'b0;
      neg_rem_q <= 1'b0;
      dz_q      <= 1'b0;
      dvd_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (arith) begin
            neg_res_q <= neg_a ^ neg_b;
            neg_rem_q <= neg_a;
            dz_q      <= (cmd_rt == '0);
            dvd_q     <= cmd_rs;
            state_q   <= cmd_funct[1] ? ST_DIV : ST_MUL;
          end else if (accept && fn_is_read(cmd_funct)) begin
            rsp_valid <= 1'b1;
            rsp_data  <= (cmd_funct == FN_MFHI) ? hi_q : lo_q;
          end
        end
        ST_MUL: begin
          if (mul_done) begin
            hi_q    <= prod_fix[2*WIDTH-1:WIDTH];
            lo_q    <= prod_fix[WIDTH-1:0];
            state_q <= ST_IDLE;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            if (dz_q) begin
              lo_q <= '1;
              hi_q <= dvd_q;
            end else begin
              lo_q <= neg_res_q ? (~quot + 1'b1) : quot;
              hi_q <= neg_rem_q ? (~rem + 1'b1) : rem;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_hilo_chk.sv
`timescale 1ns/1ps
module muldiv_hilo_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [5:0]       cmd_funct,
  input logic             busy,
  input logic             rsp_valid,
  input logic [WIDTH-1:0] rsp_data,
  input logic [WIDTH-1:0] hi_q,
  input logic [WIDTH-1:0] lo_q
);
  localparam int LW = $clog2(WIDTH + 3);
  logic [LW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    busy && run_len == LW'(WIDTH) |=> !busy); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    busy && run_len < LW'(WIDTH) |=> busy); // R7
  AST_HILO_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(hi_q) && $stable(lo_q)); // R7
  AST_HILO_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> $stable(hi_q) && $stable(lo_q)); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_funct[5:2] == 4'b0110 |=> busy); // R11
  AST_NO_RSP_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rsp_valid); // R9
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(cmd_valid && cmd_ready && (cmd_funct == 6'h10 || cmd_funct == 6'h12))); // R8
  AST_RSP_HI_VALUE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $past(cmd_funct) == 6'h10 |-> rsp_data == $past(hi_q)); // R8
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_muldiv_hilo.sv
`timescale 1ns/1ps
module sim_muldiv_hilo;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [5:0] cmd_funct = '0;
  logic [W-1:0] cmd_rs = '0, cmd_rt = '0;
  logic cmd_ready, busy, rsp_valid;
  logic [W-1:0] rsp_data;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic last_rv;
  logic [W-1:0] last_rd;

  always #2.5 clk = ~clk;

  muldiv_hilo #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_funct(cmd_funct), .cmd_rs(cmd_rs), .cmd_rt(cmd_rt),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present a command; returns at the negedge following its acceptance
  task automatic send(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_funct = f; cmd_rs = a; cmd_rt = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    last_rv = rsp_valid;
    last_rd = rsp_data;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_reg(input logic [5:0] f, input string req, output logic [W-1:0] v);
    send(f, '0, '0);
    chk({req, " rsp_valid"}, W'(last_rv), W'(1));
    v = last_rd;
  endtask

  task automatic reference(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                           output logic [W-1:0] hi, output logic [W-1:0] lo);
    logic signed [63:0] sa, sb, sq, sr;
    logic [63:0] ua, ub, p;
    sa = {{32{a[W-1]}}, a}; sb = {{32{b[W-1]}}, b};
    ua = {32'h0, a};        ub = {32'h0, b};
    case (f)
      6'h18: begin p = sa * sb; hi = p[63:32]; lo = p[31:0]; end
      6'h19: begin p = ua * ub; hi = p[63:32]; lo = p[31:0]; end
      6'h1A: if (b == '0) begin lo = '1; hi = a; end
             else begin sq = sa / sb; sr = sa % sb; lo = sq[31:0]; hi = sr[31:0]; end
      default: if (b == '0) begin lo = '1; hi = a; end
               else begin lo = a / b; hi = a % b; end
    endcase
  endtask

  task automatic run_op(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string req);
    logic [W-1:0] eh, el, gh, gl;
    reference(f, a, b, eh, el);
    send(f, a, b);
    wait_idle();
    read_reg(6'h10, req, gh);
    read_reg(6'h12, req, gl);
    chk({req, " HI"}, gh, eh);
    chk({req, " LO"}, gl, el);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    @(negedge clk);
    chk("R1 busy", W'(busy), '0);
    chk("R1 ready", W'(cmd_ready), W'(1));
    chk("R1 rsp_valid", W'(rsp_valid), '0);
    read_reg(6'h10, "R1", v); chk("R1 HI", v, '0);
    read_reg(6'h12, "R1", v); chk("R1 LO", v, '0);
  endtask

  task automatic t_mult();
    run_op(6'h18, -32'sd3, 32'd7, "R2 neg*pos");
    run_op(6'h18, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
    run_op(6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 -1*-1");
    run_op(6'h18, 32'h7FFF_FFFF, 32'd2, "R2 max*2");
  endtask

  task automatic t_multu();
    run_op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 ones*ones");
    run_op(6'h19, 32'h1234_5678, 32'h9ABC_DEF0, "R3 mixed");
    run_op(6'h19, 32'h8000_0000, 32'd0, "R3 times zero");
  endtask

  task automatic t_div();
    run_op(6'h1A, -32'sd7, 32'd2, "R4 neg/pos");
    run_op(6'h1A, 32'd7, -32'sd2, "R4 pos/neg");
    run_op(6'h1A, -32'sd7, -32'sd2, "R4 neg/neg");
    run_op(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, "R4 min/-1");
    run_op(6'h1A, 32'd100, 32'd7, "R4 pos/pos");
  endtask

  task automatic t_divu();
    run_op(6'h1B, 32'hFFFF_FFFF, 32'd3, "R5 big/3");
    run_op(6'h1B, 32'd5, 32'd10, "R5 small/large");
    run_op(6'h1B, 32'h8000_0001, 32'h8000_0000, "R5 top bit");
  endtask

  task automatic t_divzero();
    run_op(6'h1A, -32'sd5, 32'd0, "R6 signed by zero");
    run_op(6'h1B, 32'hDEAD_BEEF, 32'd0, "R6 unsigned by zero");
  endtask

  task automatic t_latency();
    int n = 0;
    send(6'h1A, 32'd1000, 32'd3);
    while (busy) begin
      n++;
      if (cmd_ready) begin
        checks++; failures++;
        $display("FAIL R7 ready high while busy actual=1 expected=0");
      end
      @(negedge clk);
    end
    chk("R7 busy cycles", W'(n), W'(W + 1));
  endtask

  task automatic t_stall();
    logic [W-1:0] eh, el, v;
    reference(6'h19, 32'hABCD_0123, 32'h0000_FFFF, eh, el);
    send(6'h19, 32'hABCD_0123, 32'h0000_FFFF);
    read_reg(6'h12, "R9 stalled read", v);
    chk("R9 stalled read LO", v, el);
    reference(6'h1A, -32'sd50, 32'd6, eh, el);
    send(6'h1B, 32'd9, 32'd4);
    send(6'h1A, -32'sd50, 32'd6);
    wait_idle();
    read_reg(6'h10, "R9 back-to-back", v);
    chk("R9 back-to-back HI", v, eh);
  endtask

  task automatic t_unknown();
    logic [W-1:0] eh, el, v;
    reference(6'h18, 32'd12345, -32'sd9, eh, el);
    send(6'h18, 32'd12345, -32'sd9);
    wait_idle();
    send(6'h20, 32'h1111_1111, 32'h2222_2222);
    chk("R10 no response", W'(last_rv), '0);
    chk("R10 not busy", W'(busy), '0);
    send(6'h11, 32'h3333_3333, 32'h4444_4444);
    chk("R10 no response 0x11", W'(last_rv), '0);
    read_reg(6'h10, "R10", v); chk("R10 HI kept", v, eh);
    read_reg(6'h12, "R10", v); chk("R10 LO kept", v, el);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_mult();
    t_multu();
    t_div();
    t_divu();
    t_divzero();
    t_latency();
    t_stall();
    t_unknown();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule